// File: doc/BRIEF.md
# Latched Status Summary Byte with Service Request

This block holds the eight-bit status summary that a measurement instrument's remote-control port offers to its host. Single-cycle event pulses mark a finished measurement, a finished calibration or zeroing run, a bad entry, a measurement or calibration fault, and a limit violation. A level input reports that the output queue holds a message. A masked OR of an external event status register supplies one more summary bit. Every bit latches, so a short condition stays visible until the host collects it.

The host drives a small command port. It can read the byte, load the service request enable mask, clear the status, or issue a device reset. A read returns the byte as it stood, then empties every latched bit except the request-service bit. Only clear-status empties the request-service bit. A device reset leaves the byte untouched. The request-service bit sets when any latched bit other than itself meets a set bit of the enable mask. The service request line to the host follows that bit.

Top module: `status_byte_unit`

## Requirements
- R1: A one-cycle pulse on `ev_data_rdy`, `ev_calz_done`, `ev_entry_err` or `ev_meas_err` sets bit 0, 1, 2 or 3 of the status byte respectively, visible from the next cycle.
- R2: A pulse on `ev_limit` sets bit 7 only while `limit_chk_en` is 1; with `limit_chk_en` at 0 the pulse leaves the byte unchanged.
- R3: Bit 4 sets while `msg_avail` is 1. Bit 5 sets while any bit of `esr_bits` AND `ese_mask` is 1.
- R4: A set bit stays set after its source goes away, until a read or a clear-status.
- R5: Command codes on `cmd_op` (qualified by `cmd_valid`): 00 read, 01 load enable mask from `cmd_wdata`, 10 clear-status, 11 device reset. A read raises `rd_valid` for one cycle, in the following cycle, with `rd_data` equal to the byte (weights 1 to 128 for bits 0 to 7) as it stood when the read was issued. Afterwards bits 0 to 5 and 7 are cleared.
- R6: A read does not clear bit 6.
- R7: Bit 6 sets one cycle after a latched bit other than bit 6 coincides with a set bit of the enable mask. `srq` is 1 exactly when bit 6 is 1.
- R8: Bit 6 of the enable mask has no effect on bit 6 or on `srq`.
- R9: Clear-status clears the whole byte including bit 6, so `srq` falls in the next cycle.
- R10: The device reset command leaves the byte and `srq` unchanged.
- R11: An event arriving in the same cycle as a read or a clear-status is kept: its bit is set afterwards.
- R12: `rst_n` low at a clock edge clears the byte, the enable mask and `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_data_rdy | input | 1 | Pulse: measurement data ready |
| ev_calz_done | input | 1 | Pulse: calibration/zero run finished |
| ev_entry_err | input | 1 | Pulse: entry error |
| ev_meas_err | input | 1 | Pulse: measurement or calibration fault |
| ev_limit | input | 1 | Pulse: measurement out of limit |
| limit_chk_en | input | 1 | Level: limit checking active |
| msg_avail | input | 1 | Level: output queue non-empty |
| esr_bits | input | 8 | Event status register contents |
| ese_mask | input | 8 | Event status enable mask |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R5) |
| cmd_wdata | input | 8 | Enable mask value for the load command |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 8 | Status byte returned by a read |
| srq | output | 1 | Service request to the host |

## Verification
Each event source is pulsed on its own and then read twice. The first read shows that its bit is in the right position. The second read shows that the read emptied it. Level sources are held across a read, so they show up again, and then dropped, so they show up once more and then disappear. Together these separate latching from following the level. The enable mask is tried with an ordinary bit, with only bit 6, and with a clear-status and a device reset on a loaded byte. These runs separate request-service latching from self-holding and from the two kinds of clearing. Events issued in the same cycle as a read or a clear-status show whether the clear wins over a new set.

// File: rtl/stb_pkg.sv
// Shared constants and types for the status summary byte.
// Assumes an eight-bit byte whose bit positions are fixed by the host protocol.
package stb_pkg;
    localparam int STB_W     = 8;
    localparam int BIT_DRDY  = 0;
    localparam int BIT_CALZ  = 1;
    localparam int BIT_ENTRY = 2;
    localparam int BIT_MERR  = 3;
    localparam int BIT_MAV   = 4;
    localparam int BIT_ESB   = 5;
    localparam int BIT_RQS   = 6;
    localparam int BIT_LIMIT = 7;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WR_SRE  = 2'b01,
        OP_CLEAR   = 2'b10,
        OP_DEV_RST = 2'b11
    } bus_op_e;

    typedef struct packed {
        logic rd;
        logic wr_sre;
        logic clr;
        logic dev_rst;
    } bus_strobe_t;
endpackage

// File: rtl/stb_source_map.sv
// Maps the raw event inputs onto the bit positions of the status byte.
// Assumes event inputs are already synchronous to clk. The request-service
// position is always driven 0 here; that bit is produced elsewhere.
module stb_source_map
    import stb_pkg::*;
#(
    parameter int ESR_W = 8
) (
    input  logic             ev_data_rdy,
    input  logic             ev_calz_done,
    input  logic             ev_entry_err,
    input  logic             ev_meas_err,
    input  logic             ev_limit,
    input  logic             limit_chk_en,
    input  logic             msg_avail,
    input  logic [ESR_W-1:0] esr_bits,
    input  logic [ESR_W-1:0] ese_mask,
    output logic [STB_W-1:0] set_vec
);
    logic esr_summary;

    // Summary of the enabled event status bits.
    always_comb begin
        esr_summary = |(esr_bits & ese_mask);
    end

    // Place each source at its fixed bit position.
    always_comb begin
        set_vec            = '0;
        set_vec[BIT_DRDY]  = ev_data_rdy;
        set_vec[BIT_CALZ]  = ev_calz_done;
        set_vec[BIT_ENTRY] = ev_entry_err;
        set_vec[BIT_MERR]  = ev_meas_err;
        set_vec[BIT_MAV]   = msg_avail;
        set_vec[BIT_ESB]   = esr_summary;
        set_vec[BIT_LIMIT] = ev_limit & limit_chk_en;
    end
endmodule

// File: rtl/stb_latch_bank.sv
// One sticky cell per status bit. A set request always wins over a clear
// in the same cycle, so no event is lost to a read or clear-status.
// Assumes rd_clr and clr_all are single-cycle strobes.
module stb_latch_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic         rd_clr,
    input  logic         clr_all,
    output logic [W-1:0] bits_q
);
    logic any_clr;

    // Either clearing source empties the bank.
    always_comb begin
        any_clr = rd_clr | clr_all;
    end

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic cell_q;

        // Sticky cell: clear on request, new set wins over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= 1'b0;
            end else if (any_clr) begin
                cell_q <= set_vec[i];
            end else begin
                cell_q <= cell_q | set_vec[i];
            end
        end

        assign bits_q[i] = cell_q;
    end
endmodule

// File: rtl/stb_rqs_ctl.sv
// Holds the service request enable mask and the latched request-service bit.
// The request-service bit is computed from registered status bits and the
// registered mask, so it follows them by one cycle. Its own position is
// masked off so it cannot keep itself set.
module stb_rqs_ctl
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sre,
    input  logic [STB_W-1:0] wdata,
    input  logic             clr_all,
    input  logic [STB_W-1:0] stb_low,
    output logic [STB_W-1:0] sre_q,
    output logic             rqs_q
);
    localparam logic [STB_W-1:0] SELF_MASK = ~(STB_W'(1) << BIT_RQS);

    logic hit;

    // Any enabled latched bit other than the request-service bit itself.
    always_comb begin
        hit = |(stb_low & sre_q & SELF_MASK);
    end

    // Enable mask register, loaded by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sre_q <= '0;
        end else if (wr_sre) begin
            sre_q <= wdata;
        end
    end

    // Latched request-service bit; only clear-status or reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rqs_q <= 1'b0;
        end else if (clr_all) begin
            rqs_q <= 1'b0;
        end else begin
            rqs_q <= rqs_q | hit;
        end
    end
endmodule

// File: rtl/stb_bus_port.sv
// Decodes host commands into single-cycle strobes and registers read data.
// Assumes one command per cycle; a read returns the byte as it stood in the
// cycle the read was issued, one cycle later.
module stb_bus_port
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [STB_W-1:0] stb_now,
    output bus_strobe_t      strb,
    output logic             rd_valid,
    output logic [STB_W-1:0] rd_data
);
    bus_op_e op;

    // Turn the command code into one strobe per operation.
    always_comb begin
        op           = bus_op_e'(cmd_op);
        strb         = '0;
        strb.rd      = cmd_valid && (op == OP_READ);
        strb.wr_sre  = cmd_valid && (op == OP_WR_SRE);
        strb.clr     = cmd_valid && (op == OP_CLEAR);
        strb.dev_rst = cmd_valid && (op == OP_DEV_RST);
    end

    // Capture the byte on a read and flag it valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= strb.rd;
            if (strb.rd) begin
                rd_data <= stb_now;
            end
        end
    end
endmodule

// File: rtl/status_byte_unit.sv
// Top of the status summary byte: latches event sources, forms the
// request-service bit from the enable mask and serves host commands.
// The device reset command is decoded but deliberately changes no state.
module status_byte_unit
    import stb_pkg::*;
#(
    parameter int ESR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_data_rdy,
    input  logic             ev_calz_done,
    input  logic             ev_entry_err,
    input  logic             ev_meas_err,
    input  logic             ev_limit,
    input  logic             limit_chk_en,
    input  logic             msg_avail,
    input  logic [ESR_W-1:0] esr_bits,
    input  logic [ESR_W-1:0] ese_mask,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [STB_W-1:0] cmd_wdata,
    output logic             rd_valid,
    output logic [STB_W-1:0] rd_data,
    output logic             srq
);
    logic [STB_W-1:0] set_vec;
    logic [STB_W-1:0] stb_low;
    logic [STB_W-1:0] sre_mask;
    logic [STB_W-1:0] stb_now;
    logic             rqs_bit;
    bus_strobe_t      strb;

    stb_source_map #(.ESR_W(ESR_W)) u_map (
        .ev_data_rdy  (ev_data_rdy),
        .ev_calz_done (ev_calz_done),
        .ev_entry_err (ev_entry_err),
        .ev_meas_err  (ev_meas_err),
        .ev_limit     (ev_limit),
        .limit_chk_en (limit_chk_en),
        .msg_avail    (msg_avail),
        .esr_bits     (esr_bits),
        .ese_mask     (ese_mask),
        .set_vec      (set_vec)
    );

    stb_latch_bank #(.W(STB_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (strb.rd),
        .clr_all (strb.clr),
        .bits_q  (stb_low)
    );

    stb_rqs_ctl u_rqs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sre  (strb.wr_sre),
        .wdata   (cmd_wdata),
        .clr_all (strb.clr),
        .stb_low (stb_low),
        .sre_q   (sre_mask),
        .rqs_q   (rqs_bit)
    );

    stb_bus_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .stb_now   (stb_now),
        .strb      (strb),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Merge the latched bits with the request-service bit at its position.
    always_comb begin
        stb_now          = stb_low;
        stb_now[BIT_RQS] = rqs_bit;
    end

    // Service request line follows the request-service bit.
    always_comb begin
        srq = rqs_bit;
    end
endmodule

// File: rtl/stb_checker.sv
// Temporal checks on the status summary byte, bound into the top module.
module stb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       ev_data_rdy,
    input logic [7:0] stb_now,
    input logic [7:0] sre_mask,
    input logic       srq,
    input logic       rd_valid,
    input logic [7:0] rd_data
);
    logic is_rd;
    logic is_clr;
    logic is_devrst;

    always_comb begin
        is_rd     = cmd_valid && (cmd_op == 2'b00);
        is_clr    = cmd_valid && (cmd_op == 2'b10);
        is_devrst = cmd_valid && (cmd_op == 2'b11);
    end

    // R1
    drdy_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_data_rdy |=> stb_now[0]);

    // R4
    sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_now[0] && !is_rd && !is_clr) |=> stb_now[0]);

    // R5
    read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_rd |=> (rd_valid && rd_data == $past(stb_now)));

    // R6
    rqs_survives_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && stb_now[6]) |=> stb_now[6]);

    // R7
    rqs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srq) |-> $past(|(stb_now & sre_mask & 8'hBF)));

    // R9
    clear_drops_srq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_clr |=> !srq);

    // R10
    devrst_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_devrst |=> ((stb_now & $past(stb_now)) == $past(stb_now)));
endmodule

bind status_byte_unit stb_checker u_stb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .ev_data_rdy (ev_data_rdy),
    .stb_now     (stb_now),
    .sre_mask    (sre_mask),
    .srq         (srq),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
);

// File: tb/status_byte_unit_bench.sv
module status_byte_unit_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_data_rdy = 0, ev_calz_done = 0, ev_entry_err = 0;
    logic       ev_meas_err = 0, ev_limit = 0, limit_chk_en = 0, msg_avail = 0;
    logic [7:0] esr_bits = '0, ese_mask = '0;
    logic       cmd_valid = 0;
    logic [1:0] cmd_op = '0;
    logic [7:0] cmd_wdata = '0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       srq;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    status_byte_unit u_status_byte_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_data_rdy(ev_data_rdy), .ev_calz_done(ev_calz_done),
        .ev_entry_err(ev_entry_err), .ev_meas_err(ev_meas_err),
        .ev_limit(ev_limit), .limit_chk_en(limit_chk_en),
        .msg_avail(msg_avail), .esr_bits(esr_bits), .ese_mask(ese_mask),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .srq(srq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    // Driver: queue the expected byte, then issue the read.
    task automatic read_exp(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        cmd_valid = 1; cmd_op = 2'b00;
        tick();
        cmd_valid = 0;
    endtask

    task automatic command(input logic [1:0] op, input logic [7:0] wd);
        cmd_valid = 1; cmd_op = op; cmd_wdata = wd;
        tick();
        cmd_valid = 0;
    endtask

    task automatic check_srq(input logic exp, input string tag);
        n_vec++;
        if (srq !== exp) begin
            n_bad++;
            $display("FAIL %s: srq actual %0b expected %0b", tag, srq, exp);
        end
    endtask

    // Monitor: compare each returned byte with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R5: unexpected read data actual %02h expected none", rd_data);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string      t = tag_q.pop_front();
                if (rd_data !== e) begin
                    n_bad++;
                    $display("FAIL %s: rd_data actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1;
        tick();
        // R12 reset state
        check_srq(0, "R12 after reset");
        read_exp(8'h00, "R12 byte after reset");

        // R1 R4 R5: data ready pulse latches, read empties it
        ev_data_rdy = 1; tick(); ev_data_rdy = 0; tick();
        read_exp(8'h01, "R1 data ready bit0");
        read_exp(8'h00, "R5 read cleared bit0");

        // R1: remaining pulse sources at bits 1..3
        ev_calz_done = 1; tick(); ev_calz_done = 0;
        ev_entry_err = 1; tick(); ev_entry_err = 0;
        ev_meas_err  = 1; tick(); ev_meas_err  = 0;
        read_exp(8'h0E, "R1 bits1-3");

        // R2: limit gated by limit_chk_en
        ev_limit = 1; tick(); ev_limit = 0;
        read_exp(8'h00, "R2 limit ignored when disabled");
        limit_chk_en = 1; ev_limit = 1; tick(); ev_limit = 0;
        read_exp(8'h80, "R2 limit bit7");
        limit_chk_en = 0;

        // R3 R4: message-available level, then dropped
        msg_avail = 1; tick();
        read_exp(8'h10, "R3 mav bit4");
        read_exp(8'h10, "R3 mav reasserts while level high");
        msg_avail = 0; tick();
        read_exp(8'h10, "R4 mav latched after level drop");
        read_exp(8'h00, "R4 mav cleared");

        // R3: event status summary needs enable
        esr_bits = 8'h04; tick();
        read_exp(8'h00, "R3 esb masked off");
        ese_mask = 8'h04; tick(); esr_bits = 8'h00;
        read_exp(8'h20, "R3 esb bit5");
        read_exp(8'h00, "R3 esb cleared");
        ese_mask = 8'h00;

        // R7 R6: enable bit0, request service
        command(2'b01, 8'h01);
        ev_data_rdy = 1; tick(); ev_data_rdy = 0;
        tick();
        check_srq(1, "R7 srq set by enabled bit0");
        read_exp(8'h41, "R7 byte with rqs");
        check_srq(1, "R6 srq held over read");
        read_exp(8'h40, "R6 rqs survives read");

        // R9: clear-status empties everything
        command(2'b10, 8'h00);
        check_srq(0, "R9 srq after clear");
        tick();
        check_srq(0, "R9 srq stays low");
        read_exp(8'h00, "R9 byte after clear");

        // R8: enable bit 6 alone does nothing
        command(2'b01, 8'h40);
        ev_data_rdy = 1; tick(); ev_data_rdy = 0;
        tick(); tick();
        check_srq(0, "R8 self enable ignored");
        read_exp(8'h01, "R8 byte without rqs");

        // R10: device reset leaves byte alone
        ev_calz_done = 1; tick(); ev_calz_done = 0;
        command(2'b11, 8'h00);
        read_exp(8'h02, "R10 byte kept over device reset");

        // R11: events in the same cycle as read and clear
        ev_entry_err = 1; tick(); ev_entry_err = 0;
        ev_data_rdy = 1; read_exp(8'h04, "R11 read with event"); ev_data_rdy = 0;
        read_exp(8'h01, "R11 event kept over read");
        ev_meas_err = 1; tick(); ev_meas_err = 0;
        ev_calz_done = 1; command(2'b10, 8'h00); ev_calz_done = 0;
        read_exp(8'h02, "R11 event kept over clear");

        // R10: device reset with rqs set keeps srq
        command(2'b01, 8'h01);
        ev_data_rdy = 1; tick(); ev_data_rdy = 0; tick();
        command(2'b11, 8'h00);
        check_srq(1, "R10 srq kept over device reset");

        // R12: hardware reset mid-run clears byte and mask
        rst_n = 0; tick(); rst_n = 1;
        check_srq(0, "R12 srq after hw reset");
        read_exp(8'h00, "R12 byte after hw reset");
        ev_data_rdy = 1; tick(); ev_data_rdy = 0; tick(); tick();
        check_srq(0, "R12 mask cleared by hw reset");
        read_exp(8'h01, "R12 bit0 after hw reset");

        tick(); tick();
        n_vec++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R5: reads outstanding actual %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule